// File: doc/BRIEF.md
# Packed Instruction Slot Sequencer

This block is the front end of a small stack processor whose program memory holds 18-bit instruction packets. Each packet carries either four 4-bit instructions or a 2-bit branch code with a 16-bit absolute packet address. The sequencer holds the program counter and drives the address and read enable of a synchronous RAM that returns data one cycle after the address. It issues instructions one per cycle to an external stack datapath, and it resolves jumps, calls, returns and zero-tests itself.

Instructions come out of the high slot first. After each one retires, the remaining slots move up by one and a nop enters at the bottom. When the instruction being retired is the last non-nop of its packet and does not use memory, the next packet fetch is issued in the same cycle, so a full packet of datapath operations runs back to back with the next one. Inline literals are read from the cell at the program counter, which then steps past that cell. Load and store instructions hand the RAM port to the datapath while `exec_o` is high with their opcode. A jump-if-zero packet pops its flag by issuing the drop opcode.

Top module: `pkseq_core`

## Requirements
- R1: While reset is low, `mem_addr_o` is 0 and `exec_o`, `lit_push_o`, `ret_push_o` and `ret_pop_o` are all low. In the first cycle after release, a packet fetch is issued at address 0.
- R2: A packet's bits 17:16 are its branch code, and code 0 marks an instruction packet. In an instruction packet the four slots sit at bits 15:12, 11:8, 7:4 and 3:0, and they execute in that order, one per cycle. The first slot executes in the cycle the packet's data arrives. Opcodes are 0 nop, 1 literal, 2 load, 3 store, 4 to 14 datapath operations (6 is drop), and 15 return.
- R3: When a datapath operation (4 to 14) leaves only nops behind it, the fetch at the program counter is issued in the same cycle. The next packet's first slot executes in the following cycle.
- R4: Literal, load and store never share a cycle with a packet fetch. If one of them leaves only nops behind it, the fetch is issued in the cycle after it retires.
- R5: A literal issues a read at the program counter. In the next cycle, `lit_push_o` is high with `lit_data_o` equal to that cell, and the program counter now points past it.
- R6: A load raises `exec_o` for one cycle and then occupies one more cycle. A store raises `exec_o` for one cycle and retires in it.
- R7: A nop followed by a non-nop in the same packet costs one cycle. Trailing nops cost nothing. A packet of four nops costs two cycles counting its fetch.
- R8: Branch code 2 issues a fetch at the 16-bit target in bits 15:0 (bits 15:12 most significant) in the packet's arrival cycle.
- R9: Branch code 1 raises `exec_o` with opcode 6 in the arrival cycle. It fetches the target if `tos_zero_i` is high, and otherwise the next sequential packet.
- R10: Branch code 3 raises `ret_push_o` with `ret_data_o` equal to the address after the call packet, and fetches the target in the same cycle.
- R11: Return raises `ret_pop_o` and fetches at `rtop_i` in the same cycle. Any slots after it are discarded.
- R12: The program counter is 16 bits, and after a fetch at 0xFFFF the next sequential fetch is at 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | RAM address for packet and literal reads |
| mem_re_o | output | 1 | RAM read enable from the sequencer |
| mem_rdata_i | input | 18 | RAM read data, valid one cycle after the read |
| tos_zero_i | input | 1 | Top of data stack is zero |
| rtop_i | input | 16 | Top of return stack |
| op_o | output | 4 | Opcode issued to the datapath |
| exec_o | output | 1 | Datapath execute strobe |
| lit_push_o | output | 1 | Push `lit_data_o` onto the data stack |
| lit_data_o | output | 18 | Literal value |
| ret_push_o | output | 1 | Push `ret_data_o` onto the return stack |
| ret_data_o | output | 16 | Return address for a call |
| ret_pop_o | output | 1 | Pop the return stack |

## Verification
The bench records every output cycle by cycle and checks the exact cycle of each fetch, strobe and literal. A sequencer that overlapped a fetch with a load or store would show a read in that instruction's cycle. One that charged cycles for trailing nops, or skipped the wait on an all-nop packet, would move later fetches by a cycle. Branch tests use a target whose digits differ, so a reversed slot order would fetch the wrong address. Both outcomes of the zero test are run, and an opcode is placed after a return to catch a return that fails to discard the rest of its packet. A jump to 0xFFFF shows whether the counter wraps to zero.

// File: rtl/pkseq_pkg.sv
package pkseq_pkg;
  localparam int SLOT_W = 4;
  localparam int CTRL_W = 2;

  localparam logic [SLOT_W-1:0] OP_NOP  = 4'h0;
  localparam logic [SLOT_W-1:0] OP_LIT  = 4'h1;
  localparam logic [SLOT_W-1:0] OP_LD   = 4'h2;
  localparam logic [SLOT_W-1:0] OP_ST   = 4'h3;
  localparam logic [SLOT_W-1:0] OP_DROP = 4'h6;
  localparam logic [SLOT_W-1:0] OP_RET  = 4'hF;

  localparam logic [CTRL_W-1:0] CT_SEQ  = 2'd0;
  localparam logic [CTRL_W-1:0] CT_JZ   = 2'd1;
  localparam logic [CTRL_W-1:0] CT_JMP  = 2'd2;
  localparam logic [CTRL_W-1:0] CT_CALL = 2'd3;

  typedef enum logic [1:0] {ST_FETCH, ST_LOAD, ST_EXEC} seq_st_e;
  typedef enum logic [1:0] {SRC_PC, SRC_TGT, SRC_RTOP} addr_src_e;
endpackage

// File: rtl/pkseq_decode.sv
module pkseq_decode import pkseq_pkg::*; #(
  parameter int N_SLOTS = 4,
  localparam int PC_W   = N_SLOTS * SLOT_W,
  localparam int DATA_W = CTRL_W + PC_W
) (
  input  logic [DATA_W-1:0] pkt_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [SLOT_W-1:0] op_o,
  output logic [PC_W-1:0]   target_o,
  output logic              rest_nop_o
);
  logic [N_SLOTS-1:1] slot_busy;

  for (genvar g = 1; g < N_SLOTS; g++) begin : g_busy
    assign slot_busy[g] = |pkt_i[PC_W-1-g*SLOT_W -: SLOT_W];
  end

  assign ctrl_o     = pkt_i[DATA_W-1 -: CTRL_W];
  assign op_o       = pkt_i[PC_W-1 -: SLOT_W];
  assign target_o   = pkt_i[PC_W-1:0];
  assign rest_nop_o = ~|slot_busy;
endmodule

// File: rtl/pkseq_slot_reg.sv
module pkseq_slot_reg import pkseq_pkg::*; #(
  parameter int N_SLOTS = 4,
  localparam int PC_W   = N_SLOTS * SLOT_W,
  localparam int DATA_W = CTRL_W + PC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] cur_i,
  output logic [DATA_W-1:0] pkt_o
);
  logic [PC_W-1:0]   shifted;
  logic [DATA_W-1:0] pkt_q;

  // slot k takes slot k+1; bottom slot takes a nop
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_mv
    if (g == N_SLOTS - 1) begin : g_fill
      assign shifted[SLOT_W-1:0] = OP_NOP;
    end else begin : g_move
      assign shifted[PC_W-1-g*SLOT_W -: SLOT_W] = cur_i[PC_W-1-(g+1)*SLOT_W -: SLOT_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pkt_q <= '0;
    else if (en_i) pkt_q <= shift_i ? {cur_i[DATA_W-1 -: CTRL_W], shifted} : cur_i;
  end

  assign pkt_o = pkt_q;
endmodule

// File: rtl/pkseq_pc.sv
module pkseq_pc import pkseq_pkg::*; #(
  parameter int PC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            go_i,
  input  addr_src_e       src_i,
  input  logic [PC_W-1:0] target_i,
  input  logic [PC_W-1:0] rtop_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] addr_o
);
  logic [PC_W-1:0] pc_q;

  always_comb begin
    case (src_i)
      SRC_TGT:  addr_o = target_i;
      SRC_RTOP: addr_o = rtop_i;
      default:  addr_o = pc_q;
    endcase
  end

  // every sequencer read leaves pc one past the cell read; wraps at 2**PC_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else if (go_i) pc_q <= addr_o + PC_W'(1);
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/pkseq_core.sv
module pkseq_core import pkseq_pkg::*; #(
  parameter int N_SLOTS = 4,
  localparam int PC_W   = N_SLOTS * SLOT_W,
  localparam int DATA_W = CTRL_W + PC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [PC_W-1:0]   mem_addr_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              tos_zero_i,
  input  logic [PC_W-1:0]   rtop_i,
  output logic [SLOT_W-1:0] op_o,
  output logic              exec_o,
  output logic              lit_push_o,
  output logic [DATA_W-1:0] lit_data_o,
  output logic              ret_push_o,
  output logic [PC_W-1:0]   ret_data_o,
  output logic              ret_pop_o
);
  seq_st_e           st_q, st_d;
  logic              ph2_q, ph2_d;
  logic [DATA_W-1:0] pkt_q, cur_pkt;
  logic [CTRL_W-1:0] dec_ctrl;
  logic [SLOT_W-1:0] dec_op;
  logic [PC_W-1:0]   dec_target, pc_q;
  logic              rest_nop;
  logic              go, pkt_en, pkt_shift;
  addr_src_e         src;

  // first slot runs straight from the RAM in the arrival cycle
  assign cur_pkt = (st_q == ST_LOAD) ? mem_rdata_i : pkt_q;

  pkseq_decode #(.N_SLOTS(N_SLOTS)) u_dec (
    .pkt_i      (cur_pkt),
    .ctrl_o     (dec_ctrl),
    .op_o       (dec_op),
    .target_o   (dec_target),
    .rest_nop_o (rest_nop)
  );

  pkseq_slot_reg #(.N_SLOTS(N_SLOTS)) u_slots (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (pkt_en),
    .shift_i (pkt_shift),
    .cur_i   (cur_pkt),
    .pkt_o   (pkt_q)
  );

  pkseq_pc #(.PC_W(PC_W)) u_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go),
    .src_i    (src),
    .target_i (dec_target),
    .rtop_i   (rtop_i),
    .pc_o     (pc_q),
    .addr_o   (mem_addr_o)
  );

  always_comb begin
    st_d       = ST_EXEC;
    ph2_d      = 1'b0;
    go         = 1'b0;
    src        = SRC_PC;
    pkt_en     = 1'b0;
    pkt_shift  = 1'b0;
    exec_o     = 1'b0;
    op_o       = dec_op;
    lit_push_o = 1'b0;
    ret_push_o = 1'b0;
    ret_pop_o  = 1'b0;
    if (st_q == ST_FETCH) begin
      go   = 1'b1;
      st_d = ST_LOAD;
    end else if (dec_ctrl != CT_SEQ) begin
      go   = 1'b1;
      st_d = ST_LOAD;
      case (dec_ctrl)
        CT_JZ: begin
          exec_o = 1'b1;
          op_o   = OP_DROP;
          src    = tos_zero_i ? SRC_TGT : SRC_PC;
        end
        CT_CALL: begin
          ret_push_o = 1'b1;
          src        = SRC_TGT;
        end
        default: src = SRC_TGT;
      endcase
    end else if (ph2_q) begin
      // second cycle of literal or load
      lit_push_o = (dec_op == OP_LIT);
      pkt_en     = 1'b1;
      pkt_shift  = 1'b1;
    end else begin
      case (dec_op)
        OP_NOP: begin
          if (rest_nop) begin
            go   = 1'b1;
            st_d = ST_LOAD;
          end else begin
            pkt_en    = 1'b1;
            pkt_shift = 1'b1;
          end
        end
        OP_LIT: begin
          go     = 1'b1;
          ph2_d  = 1'b1;
          pkt_en = 1'b1;
        end
        OP_LD: begin
          exec_o = 1'b1;
          ph2_d  = 1'b1;
          pkt_en = 1'b1;
        end
        OP_ST: begin
          exec_o    = 1'b1;
          pkt_en    = 1'b1;
          pkt_shift = 1'b1;
        end
        OP_RET: begin
          ret_pop_o = 1'b1;
          go        = 1'b1;
          src       = SRC_RTOP;
          st_d      = ST_LOAD;
        end
        default: begin
          exec_o = 1'b1;
          if (rest_nop) begin
            go   = 1'b1;
            st_d = ST_LOAD;
          end else begin
            pkt_en    = 1'b1;
            pkt_shift = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_FETCH;
      ph2_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ph2_q <= ph2_d;
    end
  end

  assign mem_re_o   = go;
  assign lit_data_o = mem_rdata_i;
  assign ret_data_o = pc_q;

  // R1
  fetch_then_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_FETCH |=> st_q == ST_LOAD);

  // R4
  mem_port_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exec_o && (op_o == OP_LD || op_o == OP_ST) && mem_re_o));

  // R5
  lit_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lit_push_o |-> $past(mem_re_o) && !mem_re_o);

  // R10
  call_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_push_o |-> mem_re_o && !ret_pop_o && !exec_o);

  // R11
  ret_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_pop_o |-> mem_re_o && mem_addr_o == rtop_i);

  // R2
  one_action_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({exec_o, lit_push_o, ret_pop_o}) <= 1);
endmodule

// File: tb/pkseq_core_tb_top.sv
module pkseq_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NLOG = 24;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic [15:0] mem_addr;
  logic        mem_re;
  logic [17:0] mem_rdata;
  logic        tos_zero = 1'b0;
  logic [15:0] rtop = 16'h0000;
  logic [3:0]  op;
  logic        exec_s, lit_push;
  logic [17:0] lit_data;
  logic        ret_push, ret_pop;
  logic [15:0] ret_data;

  logic [17:0] ram [0:63];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int re_l [NLOG], ad_l [NLOG], ex_l [NLOG], op_l [NLOG];
  int lp_l [NLOG], ld_l [NLOG], pu_l [NLOG], pd_l [NLOG], po_l [NLOG];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (mem_re) mem_rdata <= ram[mem_addr[5:0]];

  pkseq_core dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_re_o    (mem_re),
    .mem_rdata_i (mem_rdata),
    .tos_zero_i  (tos_zero),
    .rtop_i      (rtop),
    .op_o        (op),
    .exec_o      (exec_s),
    .lit_push_o  (lit_push),
    .lit_data_o  (lit_data),
    .ret_push_o  (ret_push),
    .ret_data_o  (ret_data),
    .ret_pop_o   (ret_pop)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_ram();
    for (int i = 0; i < 64; i++) ram[i] = 18'h0;
  endtask

  // reset, check idle outputs, release and record NLOG cycles
  task automatic run_prog();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "reset addr", int'(mem_addr), 0);
    chk("R1", "reset strobes", int'({exec_s, lit_push, ret_push, ret_pop}), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int c = 0; c < NLOG; c++) begin
      #1;
      re_l[c] = int'(mem_re); ad_l[c] = int'(mem_addr);
      ex_l[c] = int'(exec_s); op_l[c] = int'(op);
      lp_l[c] = int'(lit_push); ld_l[c] = int'(lit_data);
      pu_l[c] = int'(ret_push); pd_l[c] = int'(ret_data);
      po_l[c] = int'(ret_pop);
      @(negedge clk);
    end
  endtask

  task automatic exp_fetch(input int c, input int a, input string req);
    chk(req, $sformatf("fetch addr cycle %0d", c), re_l[c] != 0 ? ad_l[c] : -1, a);
  endtask

  task automatic exp_noread(input int c, input string req);
    chk(req, $sformatf("no read cycle %0d", c), re_l[c], 0);
  endtask

  task automatic exp_exec(input int c, input int o, input string req);
    chk(req, $sformatf("exec op cycle %0d", c), ex_l[c] != 0 ? op_l[c] : -1, o);
  endtask

  task automatic exp_noexec(input int c, input string req);
    chk(req, $sformatf("no exec cycle %0d", c), ex_l[c], 0);
  endtask

  task automatic t_straight();
    clear_ram();
    ram[0] = 18'h0B4E0;
    ram[1] = 18'h04000;
    run_prog();
    exp_fetch(0, 0, "R1");
    exp_exec(1, 'hB, "R2");
    exp_noread(1, "R2");
    exp_exec(2, 'h4, "R2");
    exp_exec(3, 'hE, "R3");
    exp_fetch(3, 1, "R3");
    exp_exec(4, 'h4, "R3");
    exp_fetch(4, 2, "R3");
  endtask

  task automatic t_mem_nop();
    clear_ram();
    ram[0] = 18'h01030;
    ram[1] = 18'h2ABCD;
    ram[2] = 18'h02000;
    ram[3] = 18'h00005;
    ram[4] = 18'h00000;
    ram[5] = 18'h04000;
    run_prog();
    exp_fetch(1, 1, "R5");
    chk("R5", "literal push", lp_l[2] != 0 ? ld_l[2] : -1, 'h2ABCD);
    exp_noexec(3, "R7");
    exp_exec(4, 'h3, "R6");
    exp_noread(4, "R4");
    exp_fetch(5, 2, "R4");
    exp_exec(6, 'h2, "R6");
    exp_noexec(7, "R6");
    exp_noread(7, "R4");
    exp_fetch(8, 3, "R4");
    exp_noexec(10, "R7");
    exp_exec(12, 'h5, "R7");
    exp_fetch(12, 4, "R7");
    exp_fetch(13, 5, "R7");
    exp_exec(14, 'h4, "R7");
  endtask

  task automatic t_branch(input bit zero);
    clear_ram();
    ram[6'h00] = 18'h24A10;
    ram[6'h10] = 18'h30020;
    ram[6'h20] = 18'h0EF40;
    ram[6'h11] = 18'h10030;
    ram[6'h12] = 18'h05000;
    ram[6'h30] = 18'h06000;
    rtop = 16'h4A11;
    tos_zero = zero;
    run_prog();
    exp_fetch(1, 'h4A10, "R8");
    chk("R10", "call push", pu_l[2] != 0 ? pd_l[2] : -1, 'h4A11);
    exp_fetch(2, 'h0020, "R10");
    exp_exec(3, 'hE, "R2");
    chk("R11", "return pop", po_l[4], 1);
    exp_fetch(4, 'h4A11, "R11");
    exp_exec(5, 'h6, "R9");
    exp_exec(5, 'h6, "R11");
    exp_fetch(5, zero ? 'h0030 : 'h4A12, "R9");
    exp_exec(6, zero ? 'h6 : 'h5, "R9");
  endtask

  task automatic t_wrap();
    clear_ram();
    ram[6'h00] = 18'h2FFFF;
    ram[6'h3F] = 18'h04000;
    run_prog();
    exp_fetch(1, 'hFFFF, "R8");
    exp_exec(2, 'h4, "R12");
    exp_fetch(2, 'h0000, "R12");
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    t_straight();
    t_mem_nop();
    t_branch(1'b1);
    t_branch(1'b0);
    t_wrap();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule